// File: doc/BRIEF.md
# Mode-Banked Register File with Status Save

This block holds the architectural registers of a processor core whose register view changes with the operating mode. Sixteen register indices are visible at any time. Index 15 is the program counter. The current mode is the 5-bit field at the bottom of the current status word, and it selects which physical copies the indices resolve to. The fast-interrupt mode has private copies of indices 8 to 14. The other four exception modes have private copies of indices 13 and 14 only. User and system modes share one set of registers. Each exception mode also has its own saved-status register, which brings the storage to 31 general registers plus six status words.

The block has two combinational read ports, one write port and a port for writing the whole status word. It also has two control operations, exception entry and return from exception. Exception entry saves the current status in the target mode's saved-status register, writes a return address into that mode's link register (index 14), and switches mode. Return from exception restores the status from the current mode's saved copy and loads the program counter from that mode's link register. Decoding, the ALU and vector fetch sit outside the block.

Top module: `banked_regfile`

## Requirements
- R1: After an asynchronous active-low reset, every register reads zero, the program counter is zero, and the current status is 0x000000D3 (supervisor mode, bits 7 and 6 set).
- R2: Indices 0 to 7 name the same physical registers in every mode.
- R3: Indices 8 to 12 have one private copy used only in fast-interrupt mode (mode 5'b10001) and one copy shared by all other modes.
- R4: Indices 13 and 14 have six copies: one each for fast interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011), and one shared by user (10000), system (11111) and any unlisted encoding.
- R5: Index 15 reads the program counter in all modes. In a cycle with no return, a port write to index 15 loads the written value. Otherwise, when pc_adv is high, the counter advances by PC_STEP (default 4).
- R6: A read of a register in the same cycle as a write to it returns the value held before the write.
- R7: Exception entry (exc_take with exc_mode naming an exception mode) copies the current status into the target's saved-status register and writes exc_ret_addr to the target's index 14. It sets the mode field (bits 4:0) to the target and sets bit 7. It sets bit 6 only for the fast-interrupt target and keeps all other status bits.
- R8: Return from exception, in an exception mode, copies that mode's saved status to the current status and that mode's index 14 to the program counter. In user or system mode a return changes nothing.
- R9: saved_status reads zero in user, system or unlisted modes. An exc_take whose target is not one of the five exception modes is ignored.
- R10: In a cycle with entry or return, the general write port and the status write port are ignored. Otherwise a status write loads the full status word, including the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | DATA_W | General write data |
| pc_adv | input | 1 | Advance program counter by PC_STEP |
| st_wr_en | input | 1 | Current status write enable |
| st_wr_data | input | DATA_W | Current status write value |
| exc_take | input | 1 | Exception entry request |
| exc_mode | input | 5 | Exception entry target mode |
| exc_ret_addr | input | DATA_W | Return address for target link register |
| exc_ret | input | 1 | Return-from-exception request |
| status_q | output | DATA_W | Current status word |
| saved_status | output | DATA_W | Saved status of the current mode |
| pc_q | output | DATA_W | Program counter |

## Verification
A bank decode fault makes a register read in one mode return a value written in another. Because the reads are combinational, this shows at the read ports in the same cycle that the mode changes. A fault in the saved-status or link storage stays hidden until the next return. At that point status_q and pc_q take the wrong values on the edge of the return. The bench therefore nests entries two deep and unwinds them, so that each stored copy is checked on a port within one cycle of its use.

// File: rtl/banked_rf_pkg.sv
`timescale 1ns/1ps
package banked_rf_pkg;
   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } cpu_mode_e;

   localparam int unsigned IDX_W    = 4;
   localparam int unsigned BANK_W   = 3;
   localparam int unsigned HI_BANKS = 6;
   localparam int unsigned EXC_MODES = HI_BANKS - 1;
   localparam int unsigned MID_CNT  = 5;
   localparam int unsigned LOW_CNT  = 8;
   localparam int unsigned BIT_IRQ_OFF = 7;
   localparam int unsigned BIT_FIQ_OFF = 6;

   typedef logic [BANK_W-1:0] bank_t;

   localparam bank_t BANK_SHARED = 3'd0;
   localparam bank_t BANK_FIQ    = 3'd1;
   localparam bank_t BANK_IRQ    = 3'd2;
   localparam bank_t BANK_SVC    = 3'd3;
   localparam bank_t BANK_ABT    = 3'd4;
   localparam bank_t BANK_UND    = 3'd5;
endpackage

// File: rtl/rf_bank_decode.sv
`timescale 1ns/1ps
module rf_bank_decode
   import banked_rf_pkg::*;
(
   input  logic [4:0] mode,
   output bank_t      bank,
   output logic       is_fiq,
   output logic       is_exc
);
   always_comb begin
      case (mode)
         MODE_FIQ: bank = BANK_FIQ;
         MODE_IRQ: bank = BANK_IRQ;
         MODE_SVC: bank = BANK_SVC;
         MODE_ABT: bank = BANK_ABT;
         MODE_UND: bank = BANK_UND;
         default:  bank = BANK_SHARED;
      endcase
   end

   assign is_fiq = (bank == BANK_FIQ);
   assign is_exc = (bank != BANK_SHARED);
endmodule

// File: rtl/rf_phys_store.sv
`timescale 1ns/1ps
module rf_phys_store
   import banked_rf_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PC_STEP = 4,
   parameter int unsigned RD_PORTS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          wr_fiq,
   input  bank_t                         wr_bank,
   input  logic                          lr_en,
   input  bank_t                         lr_bank,
   input  logic [DATA_W-1:0]             lr_data,
   input  logic                          ret_en,
   input  bank_t                         ret_bank,
   input  logic                          pc_adv,
   input  logic                          rd_fiq,
   input  bank_t                         rd_bank,
   input  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx,
   output logic [RD_PORTS-1:0][DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0]             pc_q
);
   localparam int unsigned MID_BASE = LOW_CNT;
   localparam int unsigned SP_IDX   = LOW_CNT + MID_CNT;
   localparam int unsigned LR_IDX   = SP_IDX + 1;
   localparam int unsigned PC_IDX   = LR_IDX + 1;
   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(PC_STEP);

   if (PC_IDX != 15) begin : g_bad_map
      $error("register map must end at index 15");
   end
   if (RD_PORTS < 1) begin : g_bad_ports
      $error("at least one read port is required");
   end

   logic [DATA_W-1:0] low_q [LOW_CNT];
   logic [DATA_W-1:0] mid_q [2][MID_CNT];
   logic [DATA_W-1:0] sp_q  [HI_BANKS];
   logic [DATA_W-1:0] lr_q  [HI_BANKS];
   logic [DATA_W-1:0] pc_r;

   for (genvar i = 0; i < LOW_CNT; i++) begin : g_low
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            low_q[i] <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))
            low_q[i] <= wr_data;
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_mid_bank
      for (genvar j = 0; j < MID_CNT; j++) begin : g_mid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mid_q[b][j] <= '0;
            else if (wr_en && wr_idx == IDX_W'(MID_BASE + j) && wr_fiq == (b == 1))
               mid_q[b][j] <= wr_data;
         end
      end
   end

   for (genvar b = 0; b < HI_BANKS; b++) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sp_q[b] <= '0;
         else if (wr_en && wr_idx == IDX_W'(SP_IDX) && wr_bank == BANK_W'(b))
            sp_q[b] <= wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lr_q[b] <= '0;
         else if (lr_en && lr_bank == BANK_W'(b))
            lr_q[b] <= lr_data;
         else if (wr_en && wr_idx == IDX_W'(LR_IDX) && wr_bank == BANK_W'(b))
            lr_q[b] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_r <= '0;
      else if (ret_en)
         pc_r <= lr_q[ret_bank];
      else if (wr_en && wr_idx == IDX_W'(PC_IDX))
         pc_r <= wr_data;
      else if (pc_adv)
         pc_r <= pc_r + STEP_V;
   end

   assign pc_q = pc_r;

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      logic [IDX_W-1:0] off;
      assign off = rd_idx[p] - IDX_W'(MID_BASE);
      always_comb begin
         if (rd_idx[p] < IDX_W'(MID_BASE))
            rd_data[p] = low_q[rd_idx[p][2:0]];
         else if (rd_idx[p] < IDX_W'(SP_IDX))
            rd_data[p] = mid_q[rd_fiq][off[2:0]];
         else if (rd_idx[p] == IDX_W'(SP_IDX))
            rd_data[p] = sp_q[rd_bank];
         else if (rd_idx[p] == IDX_W'(LR_IDX))
            rd_data[p] = lr_q[rd_bank];
         else
            rd_data[p] = pc_r;
      end
   end
endmodule

// File: rtl/rf_status_ctl.sv
`timescale 1ns/1ps
module rf_status_ctl
   import banked_rf_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] RESET_STATUS = DATA_W'(32'h0000_00D3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              entry_en,
   input  logic [4:0]        entry_mode,
   input  bank_t             entry_bank,
   input  logic              entry_fiq,
   input  logic              ret_en,
   input  bank_t             cur_bank,
   input  logic              st_wr_en,
   input  logic [DATA_W-1:0] st_wr_data,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] saved_q
);
   if (DATA_W < 16) begin : g_bad_width
      $error("status word needs at least 16 bits");
   end

   logic [DATA_W-1:0] cur_r;
   logic [DATA_W-1:0] spsr_q [EXC_MODES];
   logic [DATA_W-1:0] entry_val;

   always_comb begin
      entry_val = cur_r;
      entry_val[4:0] = entry_mode;
      entry_val[BIT_IRQ_OFF] = 1'b1;
      if (entry_fiq)
         entry_val[BIT_FIQ_OFF] = 1'b1;
   end

   for (genvar m = 0; m < EXC_MODES; m++) begin : g_spsr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            spsr_q[m] <= '0;
         else if (entry_en && entry_bank == BANK_W'(m + 1))
            spsr_q[m] <= cur_r;
      end
   end

   logic [DATA_W-1:0] ret_val;

   always_comb begin
      ret_val = '0;
      for (int m = 0; m < EXC_MODES; m++)
         if (cur_bank == BANK_W'(m + 1))
            ret_val = spsr_q[m];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_r <= RESET_STATUS;
      else if (entry_en)
         cur_r <= entry_val;
      else if (ret_en)
         cur_r <= ret_val;
      else if (st_wr_en)
         cur_r <= st_wr_data;
   end

   assign status_q = cur_r;
   assign saved_q  = ret_val;
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
   import banked_rf_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pc_adv,
   input  logic              st_wr_en,
   input  logic [DATA_W-1:0] st_wr_data,
   input  logic              exc_take,
   input  logic [4:0]        exc_mode,
   input  logic [DATA_W-1:0] exc_ret_addr,
   input  logic              exc_ret,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] saved_status,
   output logic [DATA_W-1:0] pc_q
);
   if (PC_STEP == 0) begin : g_bad_step
      $error("PC_STEP must be nonzero");
   end

   bank_t cur_bank, tgt_bank;
   logic  cur_fiq, cur_exc, tgt_fiq, tgt_exc;
   logic  entry_ok, ret_ok, wr_ok, st_ok;
   logic [1:0][IDX_W-1:0]  rd_idx;
   logic [1:0][DATA_W-1:0] rd_data;

   rf_bank_decode u_cur_dec (
      .mode   (status_q[4:0]),
      .bank   (cur_bank),
      .is_fiq (cur_fiq),
      .is_exc (cur_exc)
   );

   rf_bank_decode u_tgt_dec (
      .mode   (exc_mode),
      .bank   (tgt_bank),
      .is_fiq (tgt_fiq),
      .is_exc (tgt_exc)
   );

   assign entry_ok = exc_take & tgt_exc;
   assign ret_ok   = exc_ret & cur_exc & ~entry_ok;
   assign wr_ok    = wr_en & ~entry_ok & ~ret_ok;
   assign st_ok    = st_wr_en & ~entry_ok & ~ret_ok;

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;
   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];

   rf_phys_store #(
      .DATA_W   (DATA_W),
      .PC_STEP  (PC_STEP),
      .RD_PORTS (2)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .wr_fiq   (cur_fiq),
      .wr_bank  (cur_bank),
      .lr_en    (entry_ok),
      .lr_bank  (tgt_bank),
      .lr_data  (exc_ret_addr),
      .ret_en   (ret_ok),
      .ret_bank (cur_bank),
      .pc_adv   (pc_adv),
      .rd_fiq   (cur_fiq),
      .rd_bank  (cur_bank),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .pc_q     (pc_q)
   );

   rf_status_ctl #(
      .DATA_W (DATA_W)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .entry_en   (entry_ok),
      .entry_mode (exc_mode),
      .entry_bank (tgt_bank),
      .entry_fiq  (tgt_fiq),
      .ret_en     (ret_ok),
      .cur_bank   (cur_bank),
      .st_wr_en   (st_ok),
      .st_wr_data (st_wr_data),
      .status_q   (status_q),
      .saved_q    (saved_status)
   );
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PC_STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              pc_adv,
   input logic              st_wr_en,
   input logic              exc_take,
   input logic [4:0]        exc_mode,
   input logic              exc_ret,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] saved_status,
   input logic [DATA_W-1:0] pc_q
);
   function automatic logic exc_code(input logic [4:0] m);
      return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011) ||
             (m == 5'b10111) || (m == 5'b11011);
   endfunction

   logic entry, ret, pc_wr;
   assign entry = exc_take && exc_code(exc_mode);
   assign ret   = exc_ret && !entry && exc_code(status_q[4:0]);
   assign pc_wr = wr_en && wr_idx == 4'd15 && !entry && !ret;

   p_entry_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> saved_status == $past(status_q));
   p_entry_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (status_q[4:0] == $past(exc_mode)) && status_q[7]);
   p_entry_fiqmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (entry && exc_mode == 5'b10001) |=> status_q[6]);
   p_ret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret |=> status_q == $past(saved_status));
   p_ret_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_ret && !exc_take && !exc_code(status_q[4:0]) && !wr_en && !pc_adv && !st_wr_en)
      |=> ($stable(pc_q) && $stable(status_q)));
   p_pc_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr |=> pc_q == $past(wr_data));
   p_pc_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_adv && !pc_wr && !ret) |=> pc_q == $past(pc_q) + DATA_W'(PC_STEP));
   p_rd_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_a_idx == 4'd15 |-> rd_a_data == pc_q);
   p_no_saved_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_code(status_q[4:0]) |-> saved_status == '0);
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_a_idx     (rd_a_idx),
   .rd_a_data    (rd_a_data),
   .wr_en        (wr_en),
   .wr_idx       (wr_idx),
   .wr_data      (wr_data),
   .pc_adv       (pc_adv),
   .st_wr_en     (st_wr_en),
   .exc_take     (exc_take),
   .exc_mode     (exc_mode),
   .exc_ret      (exc_ret),
   .status_q     (status_q),
   .saved_status (saved_status),
   .pc_q         (pc_q)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0, st_wr_data = '0, exc_ret_addr = '0;
   logic        wr_en = 0, pc_adv = 0, st_wr_en = 0, exc_take = 0, exc_ret = 0;
   logic [4:0]  exc_mode = '0;
   logic [31:0] status_q, saved_status, pc_q;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   banked_regfile uut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pc_adv(pc_adv), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
      .exc_take(exc_take), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
      .exc_ret(exc_ret), .status_q(status_q), .saved_status(saved_status), .pc_q(pc_q)
   );

   // op: 0 status write, 1 register write, 2 read and compare
   localparam int NV = 22;
   localparam logic [37:0] VEC [NV] = '{
      {2'd0, 4'd0,  32'h0000_0010},
      {2'd1, 4'd3,  32'h0000_0033},
      {2'd1, 4'd9,  32'h0000_0099},
      {2'd1, 4'd13, 32'h0000_0D13},
      {2'd0, 4'd0,  32'h0000_0011},
      {2'd2, 4'd3,  32'h0000_0033},
      {2'd2, 4'd9,  32'h0000_0000},
      {2'd1, 4'd9,  32'h0000_00F9},
      {2'd2, 4'd13, 32'h0000_0000},
      {2'd1, 4'd13, 32'h0000_0F13},
      {2'd0, 4'd0,  32'h0000_0012},
      {2'd2, 4'd9,  32'h0000_0099},
      {2'd2, 4'd13, 32'h0000_0000},
      {2'd1, 4'd13, 32'h0000_0113},
      {2'd0, 4'd0,  32'h0000_001F},
      {2'd2, 4'd13, 32'h0000_0D13},
      {2'd2, 4'd9,  32'h0000_0099},
      {2'd0, 4'd0,  32'h0000_0011},
      {2'd2, 4'd9,  32'h0000_00F9},
      {2'd2, 4'd13, 32'h0000_0F13},
      {2'd0, 4'd0,  32'h0000_0012},
      {2'd2, 4'd13, 32'h0000_0113}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string req);
      rd_a_idx = idx;
      rd_b_idx = idx;
      #0.5;
      chk(req, rd_a_data, exp);
      chk(req, rd_b_data, exp);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 status", status_q, 32'h0000_00D3);
      chk("R1 pc", pc_q, 32'h0);
      rst_n = 1'b1;
      cycle();
      rd(4'd3, 32'h0, "R1 reg zero");

      // R2 R3 R4 R10: bank table
      for (int k = 0; k < NV; k++) begin
         case (VEC[k][37:36])
            2'd0: begin
               st_wr_en = 1; st_wr_data = VEC[k][31:0];
               cycle(); st_wr_en = 0;
               chk("R10 status write", status_q, VEC[k][31:0]);
            end
            2'd1: begin
               wr_en = 1; wr_idx = VEC[k][35:32]; wr_data = VEC[k][31:0];
               cycle(); wr_en = 0;
            end
            default: rd(VEC[k][35:32], VEC[k][31:0], "R2 R3 R4 bank table");
         endcase
      end

      // R6: read during write sees old value
      wr_en = 1; wr_idx = 4'd5; wr_data = 32'h0000_AAAA;
      rd(4'd5, 32'h0, "R6 old value");
      cycle(); wr_en = 0;
      rd(4'd5, 32'h0000_AAAA, "R6 new value");

      // R7 R10: entry into supervisor from user, competing writes ignored
      st_wr_en = 1; st_wr_data = 32'hF000_0010; cycle(); st_wr_en = 0;
      exc_take = 1; exc_mode = 5'b10011; exc_ret_addr = 32'h100;
      wr_en = 1; wr_idx = 4'd0; wr_data = 32'h77;
      st_wr_en = 1; st_wr_data = 32'h1F;
      cycle();
      exc_take = 0; wr_en = 0; st_wr_en = 0;
      chk("R7 entry status", status_q, 32'hF000_0093);
      chk("R7 saved status", saved_status, 32'hF000_0010);
      rd(4'd14, 32'h100, "R7 link written");
      rd(4'd0, 32'h0, "R10 write ignored on entry");

      // R5: write to pc wins over advance, then advance
      wr_en = 1; wr_idx = 4'd15; wr_data = 32'h200; pc_adv = 1;
      cycle(); wr_en = 0;
      chk("R5 pc write priority", pc_q, 32'h200);
      cycle(); pc_adv = 0;
      chk("R5 pc advance", pc_q, 32'h204);
      rd(4'd15, 32'h204, "R5 read index 15");

      // R7: nested entry to fast interrupt
      exc_take = 1; exc_mode = 5'b10001; exc_ret_addr = 32'h300;
      cycle(); exc_take = 0;
      chk("R7 fiq entry status", status_q, 32'hF000_00D1);
      chk("R7 fiq saved", saved_status, 32'hF000_0093);
      rd(4'd14, 32'h300, "R7 fiq link");
      rd(4'd13, 32'h0000_0F13, "R4 fiq sp kept");

      // R8: unwind both levels
      exc_ret = 1; cycle(); exc_ret = 0;
      chk("R8 restore status", status_q, 32'hF000_0093);
      chk("R8 restore pc", pc_q, 32'h300);
      chk("R8 svc saved", saved_status, 32'hF000_0010);
      exc_ret = 1; cycle(); exc_ret = 0;
      chk("R8 restore user status", status_q, 32'hF000_0010);
      chk("R8 restore user pc", pc_q, 32'h100);
      chk("R9 no saved in user", saved_status, 32'h0);

      // R8: return in user mode does nothing
      exc_ret = 1; cycle(); exc_ret = 0;
      chk("R8 ignored status", status_q, 32'hF000_0010);
      chk("R8 ignored pc", pc_q, 32'h100);

      // R9: entry to non-exception target ignored
      exc_take = 1; exc_mode = 5'b11111; exc_ret_addr = 32'h999;
      cycle(); exc_take = 0;
      chk("R9 bad target status", status_q, 32'hF000_0010);
      rd(4'd14, 32'h0, "R9 bad target link");

      // R1: reset again
      rst_n = 0; cycle();
      chk("R1 status after reset", status_q, 32'h0000_00D3);
      chk("R1 pc after reset", pc_q, 32'h0);
      rd(4'd3, 32'h0, "R1 reg after reset");
      rst_n = 1; cycle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule